// File: doc/BRIEF.md
# Terminal status word builder

This block keeps the 16-bit status word that a command/response bus terminal sends back after each command, together with the latched error outputs that go with it. A message sequencer tells it when a new command has been accepted, when the in-command phase begins, when words arrive, and when the message ends. The subsystem supplies live active-low condition pins. Those pins are read only at the instant the sequencer asks for a status update. Between updates the word holds steady.

The block also keeps two things. One is a message-error latch, set by word or format errors or by an illegal-command mark, and cleared when the next command starts. The other is a self-test-failure latch, cleared when a status transmission starts. It raises a fixed-length good-block pulse when a receive command has brought in exactly the number of words it announced. It also produces the data-request strobe, which a busy subsystem suppresses for transmit data but not for receive data.

Top module: `term_status_word`

## Requirements
- R1: After synchronous reset, status_word is 0 and msg_err_n, rt_fail_n and good_blk_n are high. data_req_n is high while neither want input is asserted.
- R2: On a cycle with status_upd high, status_word loads as follows. Bits 15:11 take term_addr. Bit 8 is set when srq_n is low, bit 3 when busy_n is low, bit 2 when ssflag_n is low and bit 0 when tflag_n is low; each is cleared when its pin is high. Bits 9 and 7:5 are zero. Without status_upd the word does not change, whatever the pins do.
- R3: Bit 4 of the next status word equals cmd_bcast as sampled with the most recent cmd_valid.
- R4: A low illegal_n in the cycle where in_cmd goes from low to high marks the command illegal. msg_err_n then falls one cycle later, and bit 10 is set at the next update. A low illegal_n while in_cmd is steady has no effect.
- R5: word_err drives msg_err_n low from the next cycle until a cycle with cmd_valid. If word_err and cmd_valid share a cycle, msg_err_n goes low. Bit 10 of an updated word equals the inverse of msg_err_n at the update.
- R6: Bit 1 is set at an update only when all of the following hold: abc_n is low; the command was a mode command (subaddress 0 or 31); its mode code (cmd_wc) is 0; cmd_tx is 1; and it was not marked illegal. Otherwise bit 1 is cleared.
- R7: st_fail drives rt_fail_n low from the next cycle, and the latch holds. stat_tx_start clears it, but st_fail in the same cycle keeps it low.
- R8: data_req_n is low whenever want_rx_data is high. It is also low when want_tx_data is high and status bit 3 (busy) is clear. Otherwise it is high.
- R9: A msg_end can start a good-block pulse. The conditions are: the command was a receive (cmd_tx 0) and not a mode command; it was not illegal; msg_err_n is high; word_err is low that cycle; and the rx_word pulses counted since cmd_valid equal cmd_wc, where 0 means 32. When all hold, good_blk_n is low for exactly GB_CYCLES cycles, starting the cycle after msg_end. Otherwise no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| term_addr | input | 5 | Assigned terminal address |
| cmd_valid | input | 1 | New valid command accepted (one cycle) |
| cmd_bcast | input | 1 | Command was a broadcast |
| cmd_tx | input | 1 | Command direction, 1 = transmit |
| cmd_subaddr | input | 5 | Command subaddress / mode field |
| cmd_wc | input | 5 | Word count or mode code |
| in_cmd | input | 1 | Terminal is servicing the command |
| illegal_n | input | 1 | Active-low illegal-command mark |
| word_err | input | 1 | Format or word error seen |
| status_upd | input | 1 | Status word update instant |
| srq_n | input | 1 | Active-low service request |
| busy_n | input | 1 | Active-low subsystem busy |
| ssflag_n | input | 1 | Active-low subsystem flag |
| tflag_n | input | 1 | Active-low terminal flag |
| abc_n | input | 1 | Active-low accept bus control |
| st_fail | input | 1 | Self-test failure detected |
| stat_tx_start | input | 1 | Status word transmission starts |
| want_tx_data | input | 1 | Sequencer needs transmit data |
| want_rx_data | input | 1 | Sequencer has receive data |
| rx_word | input | 1 | One received data word (one cycle) |
| msg_end | input | 1 | Message ends (one cycle) |
| status_word | output | 16 | Current status word |
| msg_err_n | output | 1 | Active-low message error |
| rt_fail_n | output | 1 | Active-low latched self-test failure |
| data_req_n | output | 1 | Active-low data request |
| good_blk_n | output | 1 | Active-low good-block pulse |

## Verification
Both latches can be asked to set and to clear in the same clock. The message-error latch can see word_err together with cmd_valid, and the failure latch can see st_fail together with stat_tx_start. The bench drives each pair into one cycle on purpose and expects the set to win. It then applies the clear alone and expects the output to return high. Random messages mix in illegal marks, word errors, off-by-one word counts and bus-control mode commands, and each resulting status word and good-block pulse is compared with a bench model.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

    localparam int ADDR_W = 5;
    localparam int SA_W   = 5;
    localparam int WC_W   = 5;
    localparam int CNT_W  = WC_W + 1;

    typedef struct packed {
        logic            bcast;
        logic            tx;
        logic [SA_W-1:0] subaddr;
        logic [WC_W-1:0] wc;
    } cmd_t;

    // Field order gives the bit layout of the returned word.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;    // 15:11
        logic              me;      // 10
        logic              rsv9;    // 9
        logic              srq;     // 8
        logic [2:0]        rsv7_5;  // 7:5
        logic              bcast;   // 4
        logic              busy;    // 3
        logic              ssf;     // 2
        logic              dbca;    // 1
        logic              tf;      // 0
    } status_t;

    function automatic logic is_mode(input cmd_t c);
        return (c.subaddr == '0) || (c.subaddr == '1);
    endfunction

    function automatic logic is_bus_ctl(input cmd_t c);
        return is_mode(c) && c.tx && (c.wc == '0);
    endfunction

    function automatic logic [CNT_W-1:0] words_due(input logic [WC_W-1:0] wc);
        return (wc == '0) ? CNT_W'(1 << WC_W) : {1'b0, wc};
    endfunction

endpackage

// File: rtl/tsb_cmd_track.sv
module tsb_cmd_track
    import tsb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_valid,
    input  cmd_t cmd_in,
    input  logic in_cmd,
    input  logic illegal_n,
    input  logic word_err,
    output cmd_t cmd_q,
    output logic illegal_q,
    output logic me_q
);
    logic in_cmd_d;
    logic ill_mark;

    assign ill_mark = in_cmd && !in_cmd_d && !illegal_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            in_cmd_d  <= 1'b0;
            illegal_q <= 1'b0;
            me_q      <= 1'b0;
        end else begin
            in_cmd_d <= in_cmd;
            if (cmd_valid)
                cmd_q <= cmd_in;
            // A set in the same cycle as the new-command clear wins.
            illegal_q <= (illegal_q && !cmd_valid) || ill_mark;
            me_q      <= (me_q && !cmd_valid) || ill_mark || word_err;
        end
    end
endmodule

// File: rtl/tsb_status_reg.sv
module tsb_status_reg
    import tsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              status_upd,
    input  logic [ADDR_W-1:0] term_addr,
    input  cmd_t              cmd_q,
    input  logic              illegal_q,
    input  logic              me_q,
    input  logic              srq_n,
    input  logic              busy_n,
    input  logic              ssflag_n,
    input  logic              tflag_n,
    input  logic              abc_n,
    input  logic              st_fail,
    input  logic              stat_tx_start,
    output status_t           sw_q,
    output logic              fail_q
);
    status_t sw_next;

    always_comb begin
        sw_next        = '0;
        sw_next.addr   = term_addr;
        sw_next.me     = me_q;
        sw_next.srq    = !srq_n;
        sw_next.bcast  = cmd_q.bcast;
        sw_next.busy   = !busy_n;
        sw_next.ssf    = !ssflag_n;
        sw_next.dbca   = !abc_n && is_bus_ctl(cmd_q) && !illegal_q;
        sw_next.tf     = !tflag_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q   <= '0;
            fail_q <= 1'b0;
        end else begin
            if (status_upd)
                sw_q <= sw_next;
            fail_q <= (fail_q && !stat_tx_start) || st_fail;
        end
    end
endmodule

// File: rtl/tsb_good_block.sv
module tsb_good_block
    import tsb_pkg::*;
#(
    parameter int GB_CYCLES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_valid,
    input  cmd_t cmd_q,
    input  logic illegal_q,
    input  logic me_q,
    input  logic word_err,
    input  logic rx_word,
    input  logic msg_end,
    output logic good_blk_n
);
    localparam int PC_W = $clog2(GB_CYCLES + 1);

    logic [CNT_W-1:0] got_q;
    logic [PC_W-1:0]  pulse_q;
    logic             block_ok;

    assign block_ok = msg_end && !cmd_q.tx && !is_mode(cmd_q) && !illegal_q
                      && !me_q && !word_err && (got_q == words_due(cmd_q.wc));

    always_ff @(posedge clk) begin
        if (rst) begin
            got_q   <= '0;
            pulse_q <= '0;
        end else begin
            if (cmd_valid)
                got_q <= '0;
            else if (rx_word && (got_q != '1))
                got_q <= got_q + 1'b1;

            if (block_ok)
                pulse_q <= PC_W'(GB_CYCLES);
            else if (pulse_q != '0)
                pulse_q <= pulse_q - 1'b1;
        end
    end

    assign good_blk_n = (pulse_q == '0);
endmodule

// File: rtl/term_status_word.sv
module term_status_word
    import tsb_pkg::*;
#(
    parameter int GB_CYCLES = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  term_addr,
    input  logic        cmd_valid,
    input  logic        cmd_bcast,
    input  logic        cmd_tx,
    input  logic [4:0]  cmd_subaddr,
    input  logic [4:0]  cmd_wc,
    input  logic        in_cmd,
    input  logic        illegal_n,
    input  logic        word_err,
    input  logic        status_upd,
    input  logic        srq_n,
    input  logic        busy_n,
    input  logic        ssflag_n,
    input  logic        tflag_n,
    input  logic        abc_n,
    input  logic        st_fail,
    input  logic        stat_tx_start,
    input  logic        want_tx_data,
    input  logic        want_rx_data,
    input  logic        rx_word,
    input  logic        msg_end,
    output logic [15:0] status_word,
    output logic        msg_err_n,
    output logic        rt_fail_n,
    output logic        data_req_n,
    output logic        good_blk_n
);
    cmd_t    cmd_in, cmd_q;
    logic    illegal_q, me_q, fail_q;
    status_t sw_q;

    assign cmd_in = '{bcast: cmd_bcast, tx: cmd_tx, subaddr: cmd_subaddr, wc: cmd_wc};

    tsb_cmd_track u_track (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_in    (cmd_in),
        .in_cmd    (in_cmd),
        .illegal_n (illegal_n),
        .word_err  (word_err),
        .cmd_q     (cmd_q),
        .illegal_q (illegal_q),
        .me_q      (me_q)
    );

    tsb_status_reg u_status (
        .clk           (clk),
        .rst           (rst),
        .status_upd    (status_upd),
        .term_addr     (term_addr),
        .cmd_q         (cmd_q),
        .illegal_q     (illegal_q),
        .me_q          (me_q),
        .srq_n         (srq_n),
        .busy_n        (busy_n),
        .ssflag_n      (ssflag_n),
        .tflag_n       (tflag_n),
        .abc_n         (abc_n),
        .st_fail       (st_fail),
        .stat_tx_start (stat_tx_start),
        .sw_q          (sw_q),
        .fail_q        (fail_q)
    );

    tsb_good_block #(.GB_CYCLES(GB_CYCLES)) u_gb (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_q      (cmd_q),
        .illegal_q  (illegal_q),
        .me_q       (me_q),
        .word_err   (word_err),
        .rx_word    (rx_word),
        .msg_end    (msg_end),
        .good_blk_n (good_blk_n)
    );

    assign status_word = sw_q;
    assign msg_err_n   = !me_q;
    assign rt_fail_n   = !fail_q;
    // Busy blocks only transmit-side requests.
    assign data_req_n  = !(want_rx_data || (want_tx_data && !sw_q.busy));
endmodule

// File: rtl/tsb_chk.sv
module tsb_chk #(
    parameter int GB_CYCLES = 6
) (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  term_addr,
    input logic        cmd_valid,
    input logic        word_err,
    input logic        status_upd,
    input logic        st_fail,
    input logic        stat_tx_start,
    input logic        want_tx_data,
    input logic        want_rx_data,
    input logic        msg_end,
    input logic [15:0] status_word,
    input logic        msg_err_n,
    input logic        rt_fail_n,
    input logic        data_req_n,
    input logic        good_blk_n
);
    localparam int RUN_W = $clog2(GB_CYCLES + 2) + 1;
    logic [RUN_W-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)
            low_run <= '0;
        else if (msg_end || good_blk_n)
            low_run <= '0;
        else if (low_run != '1)
            low_run <= low_run + 1'b1;
    end

    AST_ME_SET:    assert property (@(posedge clk) disable iff (rst)
        word_err |=> !msg_err_n);                                           // R5
    AST_ME_HOLD:   assert property (@(posedge clk) disable iff (rst)
        (!msg_err_n && !cmd_valid) |=> !msg_err_n);                         // R5
    AST_FAIL_SET:  assert property (@(posedge clk) disable iff (rst)
        st_fail |=> !rt_fail_n);                                            // R7
    AST_FAIL_CLR:  assert property (@(posedge clk) disable iff (rst)
        (stat_tx_start && !st_fail) |=> rt_fail_n);                         // R7
    AST_RX_REQ:    assert property (@(posedge clk) disable iff (rst)
        want_rx_data |-> !data_req_n);                                      // R8
    AST_TX_GATE:   assert property (@(posedge clk) disable iff (rst)
        (want_tx_data && !want_rx_data && status_word[3]) |-> data_req_n);  // R8
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !status_upd |=> $stable(status_word));                              // R2
    AST_ADDR_CAPT: assert property (@(posedge clk) disable iff (rst)
        status_upd |=> (status_word[15:11] == $past(term_addr)));           // R2
    AST_GB_CAUSE:  assert property (@(posedge clk) disable iff (rst)
        $fell(good_blk_n) |-> $past(msg_end));                              // R9
    AST_GB_WIDTH:  assert property (@(posedge clk) disable iff (rst)
        !good_blk_n |-> (low_run < RUN_W'(GB_CYCLES)));                     // R9
endmodule

bind term_status_word tsb_chk #(.GB_CYCLES(GB_CYCLES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .term_addr     (term_addr),
    .cmd_valid     (cmd_valid),
    .word_err      (word_err),
    .status_upd    (status_upd),
    .st_fail       (st_fail),
    .stat_tx_start (stat_tx_start),
    .want_tx_data  (want_tx_data),
    .want_rx_data  (want_rx_data),
    .msg_end       (msg_end),
    .status_word   (status_word),
    .msg_err_n     (msg_err_n),
    .rt_fail_n     (rt_fail_n),
    .data_req_n    (data_req_n),
    .good_blk_n    (good_blk_n)
);

// File: tb/term_status_word_tb.sv
module term_status_word_tb;
    localparam int GBC = 6;

    logic clk = 0, rst = 1;
    logic [4:0] term_addr = 0, cmd_subaddr = 0, cmd_wc = 0;
    logic cmd_valid = 0, cmd_bcast = 0, cmd_tx = 0, in_cmd = 0, illegal_n = 1;
    logic word_err = 0, status_upd = 0, srq_n = 1, busy_n = 1, ssflag_n = 1;
    logic tflag_n = 1, abc_n = 1, st_fail = 0, stat_tx_start = 0;
    logic want_tx_data = 0, want_rx_data = 0, rx_word = 0, msg_end = 0;
    logic [15:0] status_word;
    logic msg_err_n, rt_fail_n, data_req_n, good_blk_n;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic m_me = 0, m_ill = 0, m_bc = 0, m_busy = 0;

    term_status_word #(.GB_CYCLES(GBC)) u_dut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [5:0] bf_due(input logic [4:0] wc);
        return (wc == 0) ? 6'd32 : {1'b0, wc};
    endfunction

    function automatic logic [15:0] bf_status(input logic [4:0] a, input logic me, input logic srq,
        input logic bc, input logic bsy, input logic ssf, input logic dbca, input logic tf);
        logic [15:0] w;
        w = '0;
        w[15:11] = a; w[10] = me; w[8] = srq; w[4] = bc;
        w[3] = bsy; w[2] = ssf; w[1] = dbca; w[0] = tf;
        return w;
    endfunction

    task automatic run_msg();
        int kind, nw, due;
        logic ill, we, tx, good, mode, dbc;
        logic [4:0] sa, wc;
        logic s_srq, s_busy, s_ssf, s_tf, s_abc;
        logic [15:0] exp;
        kind = $urandom % 4;
        case (kind)
            0: begin sa = ($urandom % 2) ? 5'd31 : 5'd0; wc = 0; tx = 1; end
            1: begin sa = 0; wc = 5'($urandom); tx = 5'($urandom) > 5'd15; end
            2: begin sa = 5'(1 + $urandom % 30); wc = 5'($urandom); tx = 0; end
            default: begin sa = 5'(1 + $urandom % 30); wc = 5'($urandom); tx = 1; end
        endcase
        mode = (sa == 0) || (sa == 31);
        dbc  = mode && tx && (wc == 0);
        ill  = ($urandom % 5) == 0;
        we   = ($urandom % 6) == 0;
        due  = bf_due(wc);
        nw   = 0;
        if (!tx && !mode) nw = due + int'($urandom % 3) - 1;
        // new command
        cmd_valid = 1; cmd_subaddr = sa; cmd_wc = wc; cmd_tx = tx;
        cmd_bcast = ($urandom % 4) == 0;
        tick();
        cmd_valid = 0; m_me = 0; m_ill = 0; m_bc = cmd_bcast;
        // in-command edge with illegal mark
        in_cmd = 1; illegal_n = ~ill;
        tick();
        illegal_n = 1; m_ill = ill; m_me = ill;
        chk("R4 illegal mark on in_cmd edge", {15'd0, msg_err_n}, {15'd0, ~m_me});
        for (int i = 0; i < nw; i++) begin
            rx_word = 1; word_err = we && (i == nw / 2);
            tick();
            if (word_err) m_me = 1;
            rx_word = 0; word_err = 0;
        end
        if (nw == 0 && we) begin
            word_err = 1; tick(); word_err = 0; m_me = 1;
        end
        chk("R5 message error latch", {15'd0, msg_err_n}, {15'd0, ~m_me});
        msg_end = 1;
        tick();
        msg_end = 0;
        good = !tx && !mode && !m_ill && !m_me && (nw == due);
        for (int k = 0; k <= GBC; k++) begin
            chk("R9 good block pulse", {15'd0, good_blk_n}, {15'd0, !(good && k < GBC)});
            tick();
        end
        in_cmd = 0;
        // status update with random pins
        term_addr = 5'($urandom);
        s_srq = 1'($urandom); s_busy = 1'($urandom); s_ssf = 1'($urandom);
        s_tf = 1'($urandom); s_abc = 1'($urandom);
        srq_n = s_srq; busy_n = s_busy; ssflag_n = s_ssf; tflag_n = s_tf; abc_n = s_abc;
        status_upd = 1;
        tick();
        status_upd = 0;
        m_busy = !s_busy;
        exp = bf_status(term_addr, m_me, !s_srq, m_bc, !s_busy, !s_ssf,
                        !s_abc && dbc && !m_ill, !s_tf);
        chk("R2 R3 R6 status word at update", status_word, exp);
        srq_n = ~s_srq; busy_n = ~s_busy; ssflag_n = ~s_ssf; tflag_n = ~s_tf; abc_n = ~s_abc;
        term_addr = ~term_addr;
        tick();
        chk("R2 status word holds between updates", status_word, exp);
        for (int w = 0; w < 4; w++) begin
            want_tx_data = w[0]; want_rx_data = w[1];
            #1;
            chk("R8 data request gating", {15'd0, data_req_n},
                {15'd0, !(w[1] || (w[0] && !m_busy))});
        end
        want_tx_data = 0; want_rx_data = 0;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5a17));
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 status word after reset", status_word, 16'h0000);
        chk("R1 outputs after reset",
            {12'd0, msg_err_n, rt_fail_n, good_blk_n, data_req_n}, 16'h000f);
        // R4: low illegal_n with in_cmd steady does nothing
        in_cmd = 1; tick();
        illegal_n = 0; tick(); tick();
        chk("R4 no mark without in_cmd edge", {15'd0, msg_err_n}, 16'd1);
        illegal_n = 1; in_cmd = 0; tick();
        // R5: error and new command in one cycle, set wins
        cmd_valid = 1; word_err = 1; tick();
        cmd_valid = 0; word_err = 0;
        chk("R5 error wins over new command", {15'd0, msg_err_n}, 16'd0);
        tick();
        chk("R5 error stays latched", {15'd0, msg_err_n}, 16'd0);
        cmd_valid = 1; tick(); cmd_valid = 0;
        chk("R5 new command clears error", {15'd0, msg_err_n}, 16'd1);
        // R7: failure latch, set wins over clear
        st_fail = 1; tick(); st_fail = 0;
        chk("R7 failure latched", {15'd0, rt_fail_n}, 16'd0);
        tick();
        chk("R7 failure held", {15'd0, rt_fail_n}, 16'd0);
        st_fail = 1; stat_tx_start = 1; tick(); st_fail = 0; stat_tx_start = 0;
        chk("R7 persistent fault wins over clear", {15'd0, rt_fail_n}, 16'd0);
        stat_tx_start = 1; tick(); stat_tx_start = 0;
        chk("R7 status transmission clears failure", {15'd0, rt_fail_n}, 16'd1);
        // random messages
        for (int i = 0; i < 80; i++) run_msg();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule